// File: doc/BRIEF.md
# Programmable Event-to-Interrupt Router

The router takes a space of numbered hardware events and steers them onto a bank of interrupt lines. Event 0 is a null event that never fires. Events 1 to `NUM_PIN` are external pin events. They arrive as one-cycle trigger pulses from a separate pin edge/level detector. All higher event numbers are peripheral request lines, and these are active-high levels. Every interrupt line owns one link register. That register holds the selected event number, a sticky pending flag and a transfer-enable bit that is stored and read back but does not route anything.

When the selected event fires, the line's pending flag is set and held. The interrupt output is the pending flag itself, not the raw event. Software clears the flag by writing zero to its bit. Any number of lines may select the same event, and each of them latches on its own. Writing a link register evaluates the line against the new selection in the same cycle. A line whose selected event is already active therefore latches at once.

The register port is a single-cycle write strobe with a combinational read. Link register n sits at byte address 0x300 + 4*n.

Top module: `evlink_router`

## Requirements
- R1: After reset, every link register reads 0 and every interrupt output is 0.
- R2: A link register word has the event select in bits [8:0], the pending flag in bit 16 and the transfer-enable flag in bit 24. All other bits read 0. A write stores bits [8:0] and bit 24.
- R3: Link register n answers only at byte address 0x300 + 4*n, for n below `NUM_OUT`. A write to an unaligned address, to an address below 0x300 or to an address past the last register changes nothing. A read from any such address returns 0.
- R4: Event k with 1 <= k <= `NUM_PIN` fires in every cycle in which `pin_trig[k-1]` is 1. Event e with `NUM_PIN` < e < `NUM_EVT` fires in every cycle in which `per_evt[e-NUM_PIN-1]` is 1.
- R5: When a line's selected event fires at a clock edge, that line's pending flag and its `irq_o` bit are 1 after that edge. They stay 1 after the event goes away.
- R6: A write with bit 16 = 0 clears the pending flag of the addressed line. A write with bit 16 = 1 leaves the flag unchanged. A write never sets the flag by itself.
- R7: If the selected event fires in the same cycle as a clearing write, the flag ends up 1.
- R8: A select value of 0, or of `NUM_EVT` or more, never sets the flag, whatever the event inputs do.
- R9: All lines that select the same event latch in the same cycle when it fires.
- R10: In the cycle of a write, the line is evaluated against the newly written select. If that event is active in the write cycle, the flag is 1 after the edge.
- R11: The transfer-enable bit has no effect on whether or when a line latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_trig | input | NUM_PIN | Trigger pulses for pin events 1..NUM_PIN |
| per_evt | input | NUM_EVT-NUM_PIN-1 | Active-high levels for peripheral events NUM_PIN+1.. |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_o | output | NUM_OUT | Interrupt lines, one per link register |

## Verification
The hardest case to reach is a register write that lands in the same cycle as an active event. It can be a clearing write racing a fresh trigger, or a select change onto an event that is already high. Only in those cycles do set priority and same-cycle re-evaluation differ from simpler designs. The stimulus holds peripheral levels or pin pulses steady across the write cycle on purpose. A random phase then mixes writes, pin pulses and peripheral levels on a few shared events. A behavioural model follows every line and every readback on each clock.

// File: rtl/evlink_pkg.sv
package evlink_pkg;

    localparam int CSR_AW   = 12;
    localparam int CSR_DW   = 32;
    localparam int SEL_W    = 9;
    localparam int PEND_BIT = 16;
    localparam int XFER_BIT = 24;
    localparam logic [CSR_AW-1:0] LINK_BASE = 12'h300;

    typedef struct packed {
        logic             xfer;
        logic             pend;
        logic [SEL_W-1:0] sel;
    } link_slot_t;

    // Place a slot's fields at their register bit positions.
    function automatic logic [CSR_DW-1:0] slot_to_word(input link_slot_t s);
        logic [CSR_DW-1:0] w;
        w = '0;
        w[SEL_W-1:0] = s.sel;
        w[PEND_BIT]  = s.pend;
        w[XFER_BIT]  = s.xfer;
        return w;
    endfunction

endpackage

// File: rtl/evlink_fire_vec.sv
module evlink_fire_vec #(
    parameter int NUM_PIN = 16,
    parameter int NUM_EVT = 475
) (
    input  logic [NUM_PIN-1:0]         pin_trig,
    input  logic [NUM_EVT-NUM_PIN-2:0] per_evt,
    output logic [NUM_EVT-1:0]         fire
);
    // Event 0 is the null event; pins follow; peripheral levels on top.
    assign fire = {per_evt, pin_trig, 1'b0};
endmodule

// File: rtl/evlink_slot.sv
module evlink_slot
    import evlink_pkg::*;
#(
    parameter int SPAN = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CSR_DW-1:0] wdata,
    input  logic [SPAN-1:0]   fire_pad,
    output link_slot_t        q
);
    logic [SEL_W-1:0] sel_now;
    logic             hit;
    logic             clr;
    link_slot_t       d;

    always_comb begin
        // The select being written takes effect in the write cycle.
        sel_now = wr_en ? wdata[SEL_W-1:0] : q.sel;
        hit     = fire_pad[sel_now];
        clr     = wr_en && !wdata[PEND_BIT];
        d.sel   = sel_now;
        d.xfer  = wr_en ? wdata[XFER_BIT] : q.xfer;
        d.pend  = hit || (q.pend && !clr);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/evlink_router.sv
module evlink_router
    import evlink_pkg::*;
#(
    parameter int NUM_OUT = 96,
    parameter int NUM_PIN = 16,
    parameter int NUM_EVT = 475
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PIN-1:0]         pin_trig,
    input  logic [NUM_EVT-NUM_PIN-2:0] per_evt,
    input  logic                       reg_we,
    input  logic [CSR_AW-1:0]          reg_addr,
    input  logic [CSR_DW-1:0]          reg_wdata,
    output logic [CSR_DW-1:0]          reg_rdata,
    output logic [NUM_OUT-1:0]         irq_o
);
    localparam int SPAN  = 1 << SEL_W;
    localparam int IDX_W = CSR_AW - 2;

    logic [NUM_EVT-1:0] fire;
    logic [SPAN-1:0]    fire_pad;
    logic [CSR_AW-1:0]  offset;
    logic [IDX_W-1:0]   slot_idx;
    logic               in_win;
    link_slot_t         slots [NUM_OUT];

    evlink_fire_vec #(.NUM_PIN(NUM_PIN), .NUM_EVT(NUM_EVT)) u_fire (
        .pin_trig (pin_trig),
        .per_evt  (per_evt),
        .fire     (fire)
    );

    // Selects at or above NUM_EVT land on zero padding: never fire.
    assign fire_pad = SPAN'(fire);

    assign offset   = reg_addr - LINK_BASE;
    assign slot_idx = offset[CSR_AW-1:2];
    assign in_win   = (reg_addr >= LINK_BASE) && (offset[1:0] == 2'b00)
                      && (int'(slot_idx) < NUM_OUT);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_slot
        logic wr_sel;
        assign wr_sel = reg_we && in_win && (int'(slot_idx) == g);

        evlink_slot #(.SPAN(SPAN)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_sel),
            .wdata    (reg_wdata),
            .fire_pad (fire_pad),
            .q        (slots[g])
        );

        assign irq_o[g] = slots[g].pend;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (in_win && int'(slot_idx) == i) reg_rdata = slot_to_word(slots[i]);
        end
    end
endmodule

// File: rtl/evlink_router_chk.sv
module evlink_router_chk
    import evlink_pkg::*;
#(
    parameter int NUM_OUT = 96,
    parameter int NUM_PIN = 16,
    parameter int NUM_EVT = 475
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       reg_we,
    input logic [CSR_AW-1:0]          reg_addr,
    input logic [CSR_DW-1:0]          reg_wdata,
    input logic [CSR_DW-1:0]          reg_rdata,
    input logic [NUM_OUT-1:0]         irq_o
);
    localparam logic [CSR_DW-1:0] LIVE_MASK = 32'h0101_01FF;

    int   chk_idx;
    logic chk_valid;

    always_comb begin
        chk_idx   = (int'(reg_addr) - int'(LINK_BASE)) / 4;
        chk_valid = (reg_addr >= LINK_BASE) && (reg_addr[1:0] == 2'b00)
                    && (chk_idx < NUM_OUT);
        if (!chk_valid) chk_idx = 0;
    end

    // R1: reset leaves every line low.
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> irq_o == '0);

    // R2: reserved bits never read as 1.
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~LIVE_MASK) == '0);

    // R3: a read outside the window returns 0.
    p_outside_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |-> reg_rdata == '0);

    // R5: the readback pending bit and the line agree.
    p_pend_is_line_r5: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> reg_rdata[PEND_BIT] == irq_o[chk_idx]);

    // R5: without a write, no line ever drops.
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> (($past(irq_o) & ~irq_o) == '0));

    // R6: a write keeping bit 16 at 1 drops nothing.
    p_write_one_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_wdata[PEND_BIT]) |=> (($past(irq_o) & ~irq_o) == '0));

    // R3: a single write drops at most one line.
    p_single_target_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> $countones($past(irq_o) & ~irq_o) <= 1);
endmodule

bind evlink_router evlink_router_chk #(
    .NUM_OUT(NUM_OUT), .NUM_PIN(NUM_PIN), .NUM_EVT(NUM_EVT)
) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
);

// File: tb/evlink_router_bench.sv
`timescale 1ns/1ps
module evlink_router_bench;
    localparam int NUM_OUT = 96;
    localparam int NUM_PIN = 16;
    localparam int NUM_EVT = 475;
    localparam int NUM_PER = NUM_EVT - NUM_PIN - 1;
    localparam real HALF   = 10.0;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_PIN-1:0] pin_trig = '0;
    logic [NUM_PER-1:0] per_evt  = '0;
    logic               reg_we   = 1'b0;
    logic [11:0]        reg_addr = 12'h300;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic [NUM_OUT-1:0] irq_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    int m_sel  [NUM_OUT];
    bit m_pend [NUM_OUT];
    bit m_xfer [NUM_OUT];

    always #(HALF) clk = ~clk;

    evlink_router #(.NUM_OUT(NUM_OUT), .NUM_PIN(NUM_PIN), .NUM_EVT(NUM_EVT)) u_evlink_router (
        .clk(clk), .rst(rst), .pin_trig(pin_trig), .per_evt(per_evt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic int slot_of(input logic [11:0] a);
        int off;
        if (a < 12'h300 || a[1:0] != 2'b00) return -1;
        off = (int'(a) - 'h300) / 4;
        return (off < NUM_OUT) ? off : -1;
    endfunction

    function automatic bit ev_fires(input int e);
        if (e == 0 || e >= NUM_EVT) return 1'b0;
        if (e <= NUM_PIN)           return pin_trig[e-1];
        return per_evt[e-NUM_PIN-1];
    endfunction

    function automatic logic [31:0] exp_word(input logic [11:0] a);
        int n;
        logic [31:0] w;
        n = slot_of(a);
        w = '0;
        if (n >= 0) begin
            w[8:0] = 9'(m_sel[n]);
            w[16]  = m_pend[n];
            w[24]  = m_xfer[n];
        end
        return w;
    endfunction

    task automatic check(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Apply inputs for one cycle, advance the model, compare at the next negedge.
    task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d);
        int w;
        int s;
        logic [NUM_OUT-1:0] exp_irq;
        reg_we = we; reg_addr = a; reg_wdata = d;
        w = we ? slot_of(a) : -1;
        for (int n = 0; n < NUM_OUT; n++) begin
            s = (n == w) ? int'(d[8:0]) : m_sel[n];
            m_pend[n] = ev_fires(s) || (m_pend[n] && !((n == w) && !d[16]));
            m_sel[n]  = s;
            if (n == w) m_xfer[n] = d[24];
        end
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        for (int n = 0; n < NUM_OUT; n++) exp_irq[n] = m_pend[n];
        check("irq_o", 128'(irq_o), 128'(exp_irq));
        check("reg_rdata", 128'(reg_rdata), 128'(exp_word(reg_addr)));
    endtask

    function automatic logic [11:0] ad(input int n);
        return 12'('h300 + 4 * n);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int n = 0; n < NUM_OUT; n++) begin m_sel[n] = 0; m_pend[n] = 0; m_xfer[n] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values held in reset
        cur_req = "R1";
        reg_addr = ad(95);
        #1 check("irq_o in reset", 128'(irq_o), 128'(0));
        check("rdata in reset", 128'(reg_rdata), 128'(0));
        rst = 1'b0;
        step(0, ad(0), 0);

        // R2: field layout, bits outside fields dropped
        cur_req = "R2";
        step(1, ad(3), 32'hFEFE_FE05);
        step(0, ad(3), 0);

        // R3: invalid addresses change nothing and read 0
        cur_req = "R3";
        step(1, 12'h301, 32'h0100_0011);
        step(1, 12'h2FC, 32'h0100_0011);
        step(1, ad(96), 32'h0100_0011);
        step(0, 12'h301, 0);
        step(0, ad(96), 0);
        step(0, ad(0), 0);

        // R4: pin event 5 -> pin_trig[4]; last peripheral event -> top per bit
        cur_req = "R4";
        step(1, ad(10), 32'h0000_01DA);
        pin_trig[4] = 1'b1;
        step(0, ad(3), 0);
        pin_trig[4] = 1'b0;
        per_evt[NUM_PER-1] = 1'b1;
        step(0, ad(10), 0);
        per_evt[NUM_PER-1] = 1'b0;

        // R5: sticky after events drop
        cur_req = "R5";
        repeat (3) step(0, ad(3), 0);

        // R6: write one keeps, write zero clears, write never sets
        cur_req = "R6";
        step(1, ad(3), 32'h0001_0005);
        step(1, ad(3), 32'h0000_0005);
        step(1, ad(3), 32'h0001_0005);

        // R7: set wins over clear in the same cycle
        cur_req = "R7";
        pin_trig[4] = 1'b1;
        step(0, ad(3), 0);
        step(1, ad(3), 32'h0000_0005);
        pin_trig[4] = 1'b0;
        step(0, ad(3), 0);

        // R8: select 0 and out-of-range select never fire
        cur_req = "R8";
        step(1, ad(20), 32'h0000_0000);
        step(1, ad(21), 32'h0000_01FF);
        step(1, ad(22), 32'h0000_01DB);
        pin_trig = '1; per_evt = '1;
        step(0, ad(21), 0);
        step(0, ad(22), 0);
        pin_trig = '0; per_evt = '0;
        step(0, ad(20), 0);

        // R9: three lines share event 40
        cur_req = "R9";
        step(1, ad(30), 32'h0000_0028);
        step(1, ad(31), 32'h0000_0028);
        step(1, ad(32), 32'h0100_0028);
        per_evt[40-NUM_PIN-1] = 1'b1;
        step(0, ad(31), 0);
        per_evt[40-NUM_PIN-1] = 1'b0;
        step(0, ad(32), 0);

        // R10: new select onto an already active event latches at once
        cur_req = "R10";
        per_evt[50-NUM_PIN-1] = 1'b1;
        step(1, ad(40), 32'h0000_0032);
        step(1, ad(41), 32'h0000_0032);
        per_evt[50-NUM_PIN-1] = 1'b0;
        step(0, ad(40), 0);

        // R11: transfer-enable set or clear, same routing
        cur_req = "R11";
        step(1, ad(50), 32'h0100_0007);
        step(1, ad(51), 32'h0000_0007);
        pin_trig[6] = 1'b1;
        step(0, ad(50), 0);
        pin_trig[6] = 1'b0;
        step(0, ad(51), 0);

        // R4 R6 R7 R10: random mix on a few shared events
        cur_req = "R4";
        for (int it = 0; it < 600; it++) begin
            int pick;
            logic [8:0] sel;
            logic [11:0] a;
            pick = $urandom % 8;
            case (pick)
                0: sel = 9'd0;   1: sel = 9'd1;   2: sel = 9'd2;   3: sel = 9'd17;
                4: sel = 9'd18;  5: sel = 9'd19;  6: sel = 9'h1FF; default: sel = 9'd3;
            endcase
            a = ($urandom % 16 == 0) ? 12'h302 : ad($urandom % 8);
            pin_trig = '0;
            pin_trig[2:0] = 3'($urandom);
            per_evt[2:0]  = 3'($urandom);
            step(($urandom % 3) == 0, a, {7'd0, 1'($urandom), 7'd0, 1'($urandom), 7'd0, sel});
        end
        pin_trig = '0; per_evt = '0;
        step(0, ad(0), 0);

        done = 1'b1;
        finish_run();
    end
endmodule